// File: doc/BRIEF.md
# Arbitrated Bit-Bang Serial EEPROM Control Port

This block is one host-visible control register. Software uses it to drive an external three-wire serial EEPROM one pin transition at a time. The EEPROM pins are shared with a memory port that other requesters also use. Software sets a mode-request bit, and the block raises a request to that memory port. The request is granted only on a cycle in which the memory port reports it is not busy. Once access is granted, the block hands the pins over to the register.

While access is held, three stored bits drive the EEPROM chip select, serial clock and serial data input pins. The EEPROM's serial data output is synchronised and can be read back in the register. A read-only ready flag gives software a fixed settle delay. After every register write made while access is held, the flag drops and then comes back after a set number of clocks. The one exception is the first grant: there the flag simply rises to announce the grant. Clearing the mode-request bit gives the pins back to the memory port.

The block also carries a general external-arbitration request bit, which drives an output pin. An external-arbitration acknowledge input is synchronised and read back. There is no streaming data path: every pin is a plain level.

Top module: `eeprom_bitbang_port`

## Requirements
- R1: After reset, every stored bit is 0, the grant output and all EEPROM pins are low, and a read of the control address returns 0 when both the acknowledge input and the EEPROM data output are low.
- R2: A write with `wr_en` high and `addr` equal to the control address (default 0x1E) stores bit 6 (external request), bit 5 (mode request), bit 3 (chip select), bit 2 (clock) and bit 1 (data out). Writes to bits 7, 4 and 0 are ignored, and writes to any other address leave the register unchanged.
- R3: While the mode bit is stored and access is not yet held, the grant (`ee_sel`) rises on the first clock edge at which `mem_busy` is low. It stays low for as long as `mem_busy` is high.
- R4: The ready flag (read bit 4) rises on the same edge as the first grant, and it is never high without a grant.
- R5: While access is held, `ee_cs`, `ee_sk` and `ee_di` follow stored bits 3, 2 and 1 from the write edge onward.
- R6: While access is not held, `ee_cs`, `ee_sk` and `ee_di` are low whatever the stored bits are.
- R7: A write to the control address that keeps bit 5 set while access is held clears the ready flag at its edge. The flag goes high again exactly DELAY_CYC clock edges after that write edge. DELAY_CYC is ceil(CLK_FREQ_MHZ × READY_DELAY_NS / 1000), which is 80 at the defaults of 100 MHz and 800 ns.
- R8: Once the mode bit is cleared, the grant, the ready flag and all EEPROM pins are low from the next clock edge.
- R9: An existing grant is kept while `mem_busy` is high.
- R10: Read bit 0 shows `ee_do` after a two-flop synchroniser, so a change appears after the second rising edge. The bit reads 0 while access is not held.
- R11: Stored bit 6 drives `ext_arb_req`, and read bit 7 shows `ext_arb_ack` through the two-flop synchroniser.
- R12: A read at any address other than the control address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte address (writes and reads) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| mem_busy | input | 1 | Shared memory port is serving another requester |
| ee_sel | output | 1 | Grant: pins are connected to the register |
| ext_arb_req | output | 1 | External arbitration request level |
| ext_arb_ack | input | 1 | External arbitration acknowledge (asynchronous) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data input (driven by the block) |
| ee_do | input | 1 | EEPROM serial data output (asynchronous) |

## Verification
A grant state machine stuck or late shows up one edge after the mode write, as a wrong `ee_sel` level and as pins that do or do not follow the stored bits. Granting during `mem_busy`, or dropping the grant under traffic, shows up within one cycle of the busy change. A wrong ready-timer load or count changes the exact edge at which read bit 4 comes back. That edge is probed at random distances on both sides of DELAY_CYC after each write. Synchroniser depth errors move the cycle at which bit 0 changes after `ee_do`.

// File: rtl/eebb_pkg.sv
package eebb_pkg;

  // Bit positions in the control register; software decodes these.
  localparam int unsigned BIT_EXT_ACK = 7;
  localparam int unsigned BIT_EXT_REQ = 6;
  localparam int unsigned BIT_MODE    = 5;
  localparam int unsigned BIT_READY   = 4;
  localparam int unsigned BIT_CS      = 3;
  localparam int unsigned BIT_SK      = 2;
  localparam int unsigned BIT_DOUT    = 1;
  localparam int unsigned BIT_DIN     = 0;

  // Writable portion of the control register.
  typedef struct packed {
    logic ext_req;
    logic mode;
    logic cs;
    logic sk;
    logic dout;
  } eebb_ctl_t;

  localparam eebb_ctl_t CTL_RESET = '{default: 1'b0};

endpackage

// File: rtl/eebb_sync.sv
module eebb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_q[gi-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/eebb_arbiter.sv
module eebb_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mem_busy,
  output logic grant,
  output logic grant_set
);

  logic grant_q;

  // A pending request is taken only on an idle memory-port cycle.
  always_comb grant_set = req && !grant_q && !mem_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         grant_q <= 1'b0;
    else if (!req)      grant_q <= 1'b0;
    else if (grant_set) grant_q <= 1'b1;
  end

  assign grant = grant_q;

  p_grant_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> $past(!mem_busy && req));

  p_grant_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q && req) |=> grant_q);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !grant_q);

endmodule

// File: rtl/eebb_ready_timer.sv
module eebb_ready_timer #(
  parameter int DELAY_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,       // stored mode request
  input  logic granted,    // current grant
  input  logic grant_set,  // grant is taken at this edge
  input  logic restart,    // qualifying register write at this edge
  output logic ready
);

  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC - 1);

  logic          ready_q;
  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (!hold) begin
      ready_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (grant_set) begin
      ready_q <= 1'b1;      // first grant: flag only, no delay
      run_q   <= 1'b0;
    end else if (restart) begin
      ready_q <= 1'b0;
      run_q   <= 1'b1;
      cnt_q   <= LOAD;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        ready_q <= 1'b1;
        run_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ready = ready_q;

  p_ready_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> granted);

  p_first_grant_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> ready_q);

  p_low_while_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !ready_q);

  p_count_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

endmodule

// File: rtl/eeprom_bitbang_port.sv
module eeprom_bitbang_port
  import eebb_pkg::*;
#(
  parameter int          ADDR_W         = 8,
  parameter logic [7:0]  CTL_ADDR       = 8'h1E,
  parameter int          CLK_FREQ_MHZ   = 100,
  parameter int          READY_DELAY_NS = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              mem_busy,
  output logic              ee_sel,
  output logic              ext_arb_req,
  input  logic              ext_arb_ack,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int DELAY_RAW = (CLK_FREQ_MHZ * READY_DELAY_NS + 999) / 1000;
  localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;

  eebb_ctl_t ctl_q;
  logic      hit;
  logic      wr_hit;
  logic      grant;
  logic      grant_set;
  logic      ready;
  logic      ack_s;
  logic      din_s;
  logic      unused_wbits;

  assign hit    = (addr == ADDR_W'(CTL_ADDR));
  assign wr_hit = wr_en && hit;
  assign unused_wbits = ^{wdata[BIT_EXT_ACK], wdata[BIT_READY], wdata[BIT_DIN]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (wr_hit) begin
      ctl_q.ext_req <= wdata[BIT_EXT_REQ];
      ctl_q.mode    <= wdata[BIT_MODE];
      ctl_q.cs      <= wdata[BIT_CS];
      ctl_q.sk      <= wdata[BIT_SK];
      ctl_q.dout    <= wdata[BIT_DOUT];
    end
  end

  eebb_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ext_arb_ack, ee_do}),
    .sync_out ({ack_s, din_s})
  );

  eebb_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (ctl_q.mode),
    .mem_busy  (mem_busy),
    .grant     (grant),
    .grant_set (grant_set)
  );

  eebb_ready_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (ctl_q.mode),
    .granted   (grant),
    .grant_set (grant_set),
    .restart   (wr_hit && grant && wdata[BIT_MODE]),
    .ready     (ready)
  );

  // Pin mux: register bits only reach the pins under a grant.
  assign ee_sel      = grant;
  assign ee_cs       = grant & ctl_q.cs;
  assign ee_sk       = grant & ctl_q.sk;
  assign ee_di       = grant & ctl_q.dout;
  assign ext_arb_req = ctl_q.ext_req;

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[BIT_EXT_ACK] = ack_s;
      rdata[BIT_EXT_REQ] = ctl_q.ext_req;
      rdata[BIT_MODE]    = ctl_q.mode;
      rdata[BIT_READY]   = ready;
      rdata[BIT_CS]      = ctl_q.cs;
      rdata[BIT_SK]      = ctl_q.sk;
      rdata[BIT_DOUT]    = ctl_q.dout;
      rdata[BIT_DIN]     = grant & din_s;
    end
  end

  p_pins_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_sel |-> (!ee_cs && !ee_sk && !ee_di));

  p_ready_implies_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BIT_READY] |-> ee_sel);

endmodule

// File: tb/tb_eeprom_bitbang_port.sv
module tb_eeprom_bitbang_port;

  localparam int D = 80;           // ceil(100 MHz * 800 ns)
  localparam logic [7:0] CA = 8'h1E;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       mem_busy, ee_sel, ext_arb_req, ext_arb_ack;
  logic       ee_cs, ee_sk, ee_di, ee_do;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eeprom_bitbang_port #(
    .ADDR_W(8), .CTL_ADDR(CA), .CLK_FREQ_MHZ(100), .READY_DELAY_NS(800)
  ) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .mem_busy(mem_busy), .ee_sel(ee_sel),
    .ext_arb_req(ext_arb_req), .ext_arb_ack(ext_arb_ack),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Stored-bit view expected after writing w (bits 6,5,3,2,1 only).
  function automatic logic [7:0] stored_bits(input logic [7:0] w);
    return w & 8'h6E;
  endfunction

  function automatic logic [2:0] exp_pins(input logic g, input logic [7:0] w);
    return g ? {w[3], w[2], w[1]} : 3'b000;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = CA;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = CA;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd4242));
    rst_n = 1'b0; addr = CA; wr_en = 1'b0; wdata = '0;
    mem_busy = 1'b0; ext_arb_ack = 1'b0; ee_do = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(CA, rv);
    chk("R1 rdata", rv, 8'h00);
    chk("R1 pins", {ee_sel, ee_cs, ee_sk, ee_di, ext_arb_req}, 5'b0);

    // R2, R6, R11: store bits without requesting the port
    wr(CA, 8'hDF);
    rd(CA, rv);
    chk("R2 readback", rv, 8'h4E);
    chk("R6 pins idle without grant", {ee_sel, ee_cs, ee_sk, ee_di}, 4'b0);
    chk("R11 ext req out", ext_arb_req, 1'b1);
    ext_arb_ack = 1'b1;
    cyc(3);
    rd(CA, rv);
    chk("R11 ack readback", rv[7], 1'b1);
    rd(8'h1D, rv);
    chk("R12 other address", rv, 8'h00);
    wr(8'h1D, 8'h00);
    rd(CA, rv);
    chk("R2 other address write ignored", rv, 8'hCE);
    ee_do = 1'b1;
    cyc(3);
    rd(CA, rv);
    chk("R10 din masked without grant", rv[0], 1'b0);
    ee_do = 1'b0;

    // R3 deferral while busy
    mem_busy = 1'b1;
    wr(CA, 8'h20);
    cyc(5);
    chk("R3 deferred while busy", ee_sel, 1'b0);
    rd(CA, rv);
    chk("R4 no ready before grant", rv[4], 1'b0);
    mem_busy = 1'b0;
    cyc(1);
    chk("R3 grant after idle", ee_sel, 1'b1);
    rd(CA, rv);
    chk("R4 ready with first grant", rv[4], 1'b1);

    // R9 grant kept under traffic
    mem_busy = 1'b1;
    cyc(10);
    chk("R9 grant kept", ee_sel, 1'b1);

    // R5, R7 directed timing
    wr(CA, 8'h28);
    chk("R5 cs pin", {ee_cs, ee_sk, ee_di}, 3'b100);
    rd(CA, rv);
    chk("R7 ready low at write", rv[4], 1'b0);
    cyc(D - 1);
    rd(CA, rv);
    chk("R7 ready low before delay", rv[4], 1'b0);
    cyc(1);
    rd(CA, rv);
    chk("R7 ready high at delay", rv[4], 1'b1);

    // R10 synchroniser depth
    @(negedge clk); ee_do = 1'b1;
    cyc(1);
    rd(CA, rv);
    chk("R10 din after one edge", rv[0], 1'b0);
    cyc(1);
    rd(CA, rv);
    chk("R10 din after two edges", rv[0], 1'b1);

    // Random writes under grant: pins, readback, ready timing, din
    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      int k;
      logic dv;
      w  = 8'($urandom) | 8'h20;
      dv = 1'($urandom);
      k  = 2 + int'($urandom % (D + 6));
      mem_busy = 1'($urandom);
      ee_do = dv;
      wr(CA, w);
      chk("R5 random pins", {ee_cs, ee_sk, ee_di}, exp_pins(1'b1, w));
      chk("R11 random ext req", ext_arb_req, w[6]);
      cyc(k);
      rd(CA, rv);
      chk("R2 random readback", rv & 8'h6E, stored_bits(w));
      chk("R7 random ready", rv[4], (k >= D) ? 1'b1 : 1'b0);
      chk("R10 random din", rv[0], dv);
      chk("R9 random grant kept", ee_sel, 1'b1);
    end

    // R8 release
    mem_busy = 1'b0;
    wr(CA, 8'h0E);
    cyc(1);
    rd(CA, rv);
    chk("R8 grant released", ee_sel, 1'b0);
    chk("R8 ready cleared", rv[4], 1'b0);
    chk("R8 R6 pins idle", {ee_cs, ee_sk, ee_di}, 3'b000);

    // R3 immediate grant when idle, then R6 after release again
    wr(CA, 8'h2A);
    cyc(1);
    chk("R3 immediate grant", ee_sel, 1'b1);
    chk("R5 dout pin", {ee_cs, ee_sk, ee_di}, 3'b101);
    rd(CA, rv);
    chk("R4 ready on regrant", rv[4], 1'b1);
    wr(CA, 8'h0E);
    cyc(2);
    chk("R6 pins idle after release", {ee_sel, ee_cs, ee_sk, ee_di}, 4'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule